// File: doc/BRIEF.md
# Multicycle Load/Store Processor Datapath

This block is the 32-bit datapath of a small processor. Each instruction runs as a series of equal-length clock cycles. A single memory port serves both instruction fetch and data access. A single ALU handles the PC increment, the branch-target sum, effective addresses and register arithmetic. Five holding registers carry values from one cycle to the next: the instruction word, the memory data word, the two register operands and the ALU result.

The datapath makes no sequencing decisions of its own. An external controller supplies every mux select and write enable in each cycle, and reads back the opcode to choose its next step. The memory sits outside the block, with a combinational read port and a write that takes effect on the clock edge. The datapath supports load word, store word, R-type arithmetic, branch-if-equal and jump.

Top module: `mc_datapath`

## Requirements
- R1: After reset `pc_o` reads 0 and no memory write is requested.
- R2: In a cycle with `ir_we_i`=1, `pc_we_i`=1, `pc_src_sel_i`=00, `alu_a_sel_i`=0, `alu_b_sel_i`=01 and `alu_op_i`=00, the instruction register captures the word at the PC and the PC becomes PC+4. `opcode_o` shows IR[31:26].
- R3: With `alu_a_sel_i`=0, `alu_b_sel_i`=11 and `alu_op_i`=00, the ALU result register captures PC + (sign-extended IR[15:0] << 2). A later branch that is taken with `pc_src_sel_i`=01 loads that value into the PC.
- R4: `mem_addr_o` is the PC when `addr_sel_i`=0 and the ALU result register when it is 1.
- R5: `alu_op_i`=00 adds and 01 subtracts. For 10 the ALU decodes IR[5:0] as follows: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0).
- R6: Register 0 reads as zero even after a write to it.
- R7: With `mem_re_i`=1 the memory data register captures `mem_rdata_i`. A write with `wb_src_sel_i`=1 and `wb_dst_sel_i`=0 puts that value in the register named by IR[20:16].
- R8: With `mem_we_i`=1 the block drives operand B on `mem_wdata_o` and requests a write at the ALU result register.
- R9: With `pc_we_cond_i`=1 and `pc_we_i`=0, the PC is loaded only when the ALU zero flag is 1 (A equals B under subtract). Otherwise the PC holds.
- R10: With `pc_src_sel_i`=10 and `pc_we_i`=1, the PC becomes {PC[31:28], IR[25:0], 2'b00}.
- R11: An R-type write with `wb_dst_sel_i`=1 and `wb_src_sel_i`=0 puts the ALU result register in the register named by IR[15:11].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_we_i | input | 1 | Unconditional PC write |
| pc_we_cond_i | input | 1 | PC write gated by ALU zero |
| pc_src_sel_i | input | 2 | PC source: 00 ALU, 01 ALU register, 10 jump |
| addr_sel_i | input | 1 | Memory address: 0 PC, 1 ALU register |
| mem_re_i | input | 1 | Memory read, loads data register |
| mem_we_i | input | 1 | Memory write request |
| ir_we_i | input | 1 | Instruction register load |
| reg_we_i | input | 1 | Register file write |
| wb_dst_sel_i | input | 1 | Destination: 0 IR[20:16], 1 IR[15:11] |
| wb_src_sel_i | input | 1 | Write data: 0 ALU register, 1 data register |
| alu_a_sel_i | input | 1 | ALU A: 0 PC, 1 operand A |
| alu_b_sel_i | input | 2 | ALU B: 00 B, 01 four, 10 imm, 11 imm<<2 |
| alu_op_i | input | 2 | 00 add, 01 subtract, 10 by funct |
| mem_rdata_i | input | 32 | Memory read data |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| opcode_o | output | 6 | IR[31:26] for the controller |
| pc_o | output | 32 | Current PC |

## Verification
The fetch cycle is where two functions share one edge. The PC is incremented through the ALU while the instruction register captures the word addressed by the old PC. The bench runs instructions back to back and reads `opcode_o` after each fetch. Every following fetch must take the word stored at exactly PC+4, and a wrong overlap shows up as a wrong opcode or PC. A second overlap is provoked with a store issued right after a load: the memory data register fills while B is still being refreshed, and the stored word is compared with the model.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  typedef enum logic [2:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT
  } alu_fn_e;

  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;
  localparam logic [1:0] AOP_FUNCT = 2'b10;

  localparam logic [5:0] FUNCT_ADD = 6'h20;
  localparam logic [5:0] FUNCT_SUB = 6'h22;
  localparam logic [5:0] FUNCT_AND = 6'h24;
  localparam logic [5:0] FUNCT_OR  = 6'h25;
  localparam logic [5:0] FUNCT_SLT = 6'h2a;
endpackage

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic [AW-1:0]   ra_i,
  input  logic [AW-1:0]   rb_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i,
  input  logic            we_i,
  output logic [XLEN-1:0] rda_o,
  output logic [XLEN-1:0] rdb_o
);
  logic [XLEN-1:0] rf_q [NREG];

  always_ff @(posedge clk_i) begin
    if (we_i && wa_i != '0) rf_q[wa_i] <= wd_i;
  end

  // r0 is hardwired zero (R6)
  assign rda_o = (ra_i == '0) ? '0 : rf_q[ra_i];
  assign rdb_o = (rb_i == '0) ? '0 : rf_q[rb_i];
endmodule

// File: rtl/mcd_alu.sv
module mcd_alu
  import mcd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      op_i,
  input  logic [5:0]      funct_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o,
  output logic            zero_o
);
  alu_fn_e fn;

  always_comb begin
    fn = FN_ADD;
    unique case (op_i)
      AOP_ADD: fn = FN_ADD;
      AOP_SUB: fn = FN_SUB;
      AOP_FUNCT: begin
        unique case (funct_i)
          FUNCT_SUB: fn = FN_SUB;
          FUNCT_AND: fn = FN_AND;
          FUNCT_OR:  fn = FN_OR;
          FUNCT_SLT: fn = FN_SLT;
          default:   fn = FN_ADD;
        endcase
      end
      default: fn = FN_ADD;
    endcase
  end

  always_comb begin
    unique case (fn)
      FN_SUB:  y_o = a_i - b_i;
      FN_AND:  y_o = a_i & b_i;
      FN_OR:   y_o = a_i | b_i;
      FN_SLT:  y_o = {{(XLEN-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mcd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG),
  localparam int IMMW = 16,
  localparam int JW = 26
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pc_we_i,
  input  logic            pc_we_cond_i,
  input  logic [1:0]      pc_src_sel_i,
  input  logic            addr_sel_i,
  input  logic            mem_re_i,
  input  logic            mem_we_i,
  input  logic            ir_we_i,
  input  logic            reg_we_i,
  input  logic            wb_dst_sel_i,
  input  logic            wb_src_sel_i,
  input  logic            alu_a_sel_i,
  input  logic [1:0]      alu_b_sel_i,
  input  logic [1:0]      alu_op_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  output logic            mem_re_o,
  output logic            mem_we_o,
  output logic [5:0]      opcode_o,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_out_q;
  logic [XLEN-1:0] rda, rdb, imm_sx, alu_a, alu_b, alu_y, pc_next, jump_tgt, wd;
  logic [AW-1:0]   wa;
  logic            alu_zero, pc_load;

  assign imm_sx   = {{(XLEN-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};
  assign jump_tgt = {pc_q[XLEN-1 -: 4], ir_q[JW-1:0], 2'b00};

  assign wa = wb_dst_sel_i ? ir_q[15:11] : ir_q[20:16];
  assign wd = wb_src_sel_i ? mdr_q : alu_out_q;

  mcd_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i (clk_i),
    .ra_i  (ir_q[25:21]),
    .rb_i  (ir_q[20:16]),
    .wa_i  (wa),
    .wd_i  (wd),
    .we_i  (reg_we_i),
    .rda_o (rda),
    .rdb_o (rdb)
  );

  assign alu_a = alu_a_sel_i ? a_q : pc_q;
  always_comb begin
    unique case (alu_b_sel_i)
      2'b00:   alu_b = b_q;
      2'b01:   alu_b = XLEN'(4);
      2'b10:   alu_b = imm_sx;
      default: alu_b = {imm_sx[XLEN-3:0], 2'b00};
    endcase
  end

  mcd_alu #(.XLEN(XLEN)) u_alu (
    .op_i    (alu_op_i),
    .funct_i (ir_q[5:0]),
    .a_i     (alu_a),
    .b_i     (alu_b),
    .y_o     (alu_y),
    .zero_o  (alu_zero)
  );

  always_comb begin
    unique case (pc_src_sel_i)
      2'b00:   pc_next = alu_y;
      2'b01:   pc_next = alu_out_q;
      default: pc_next = jump_tgt;
    endcase
  end

  assign pc_load = pc_we_i | (pc_we_cond_i & alu_zero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= '0;
      ir_q      <= '0;
      mdr_q     <= '0;
      a_q       <= '0;
      b_q       <= '0;
      alu_out_q <= '0;
    end else begin
      if (pc_load)  pc_q  <= pc_next;
      if (ir_we_i)  ir_q  <= mem_rdata_i;
      if (mem_re_i) mdr_q <= mem_rdata_i;
      a_q       <= rda;
      b_q       <= rdb;
      alu_out_q <= alu_y;
    end
  end

  assign mem_addr_o  = addr_sel_i ? alu_out_q : pc_q;
  assign mem_wdata_o = b_q;
  assign mem_re_o    = mem_re_i;
  assign mem_we_o    = mem_we_i;
  assign opcode_o    = ir_q[31:26];
  assign pc_o        = pc_q;
endmodule

// File: rtl/mcd_chk.sv
module mcd_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pc_we_i,
  input logic            pc_we_cond_i,
  input logic [1:0]      pc_src_sel_i,
  input logic            ir_we_i,
  input logic            alu_a_sel_i,
  input logic [1:0]      alu_b_sel_i,
  input logic [1:0]      alu_op_i,
  input logic [XLEN-1:0] mem_rdata_i,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] ir_q,
  input logic [XLEN-1:0] a_q,
  input logic [XLEN-1:0] b_q,
  input logic [XLEN-1:0] alu_out_q
);
  // R2
  ir_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_we_i |=> ir_q == $past(mem_rdata_i));

  // R2
  pc_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_i && pc_src_sel_i == 2'b00 && !alu_a_sel_i && alu_b_sel_i == 2'b01 && alu_op_i == 2'b00)
    |=> pc_o == $past(pc_o) + 32'd4);

  // R3
  branch_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alu_a_sel_i && alu_b_sel_i == 2'b11 && alu_op_i == 2'b00)
    |=> alu_out_q == $past(pc_o) + {{14{$past(ir_q[15])}}, $past(ir_q[15:0]), 2'b00});

  // R9
  branch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_cond_i && !pc_we_i && alu_a_sel_i && alu_b_sel_i == 2'b00 && alu_op_i == 2'b01 && a_q != b_q)
    |=> $stable(pc_o));

  // R9
  branch_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_cond_i && !pc_we_i && pc_src_sel_i == 2'b01 && alu_a_sel_i && alu_b_sel_i == 2'b00 &&
     alu_op_i == 2'b01 && a_q == b_q)
    |=> pc_o == $past(alu_out_q));

  // R10
  jump_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_i && pc_src_sel_i == 2'b10)
    |=> pc_o == {$past(pc_o[31:28]), $past(ir_q[25:0]), 2'b00});
endmodule

bind mc_datapath mcd_chk #(.XLEN(XLEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pc_we_i      (pc_we_i),
  .pc_we_cond_i (pc_we_cond_i),
  .pc_src_sel_i (pc_src_sel_i),
  .ir_we_i      (ir_we_i),
  .alu_a_sel_i  (alu_a_sel_i),
  .alu_b_sel_i  (alu_b_sel_i),
  .alu_op_i     (alu_op_i),
  .mem_rdata_i  (mem_rdata_i),
  .pc_o         (pc_o),
  .ir_q         (ir_q),
  .a_q          (a_q),
  .b_q          (b_q),
  .alu_out_q    (alu_out_q)
);

// File: tb/tb_mc_datapath.sv
`timescale 1ns/1ps
module tb_mc_datapath;
  localparam int MW = 1024;
  localparam logic [5:0] OP_R = 6'h00, OP_LW = 6'h23, OP_SW = 6'h2b, OP_BEQ = 6'h04, OP_J = 6'h02;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pc_we, pc_we_cond, addr_sel, mem_re, mem_we, ir_we, reg_we, wb_dst, wb_src, a_sel;
  logic [1:0] pc_src, b_sel, aop;
  logic [31:0] rdata, maddr, wdata, pc;
  logic mre_o, mwe_o;
  logic [5:0] opc;
  logic [31:0] mem [MW];
  logic [31:0] exp_rf [32];
  logic [31:0] exp_pc;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  mc_datapath dut (
    .clk_i(clk), .rst_ni(rst_n), .pc_we_i(pc_we), .pc_we_cond_i(pc_we_cond),
    .pc_src_sel_i(pc_src), .addr_sel_i(addr_sel), .mem_re_i(mem_re), .mem_we_i(mem_we),
    .ir_we_i(ir_we), .reg_we_i(reg_we), .wb_dst_sel_i(wb_dst), .wb_src_sel_i(wb_src),
    .alu_a_sel_i(a_sel), .alu_b_sel_i(b_sel), .alu_op_i(aop), .mem_rdata_i(rdata),
    .mem_addr_o(maddr), .mem_wdata_o(wdata), .mem_re_o(mre_o), .mem_we_o(mwe_o),
    .opcode_o(opc), .pc_o(pc)
  );

  assign rdata = mem[maddr[11:2]];
  always @(posedge clk) if (mwe_o) mem[maddr[11:2]] <= wdata;

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] alu_ref(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      6'h2a:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] f);
    return {OP_R, 5'(rs), 5'(rt), 5'(rd), 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic clr();
    pc_we = 0; pc_we_cond = 0; addr_sel = 0; mem_re = 0; mem_we = 0; ir_we = 0;
    reg_we = 0; wb_dst = 0; wb_src = 0; a_sel = 0; pc_src = 2'b00; b_sel = 2'b00; aop = 2'b00;
  endtask

  task automatic tick();
    @(negedge clk);
    clr();
  endtask

  task automatic exec(input logic [31:0] ins, input string tag);
    logic [5:0] op;
    int rs, rt, rd;
    logic [31:0] ea, pc4;
    op = ins[31:26]; rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    mem[exp_pc[11:2]] <= ins;
    pc4 = exp_pc + 4;
    ea = exp_rf[rs] + sx(ins[15:0]);
    // fetch
    tick();
    mem_re = 1; ir_we = 1; b_sel = 2'b01; pc_we = 1;
    #1 check("R4 fetch address is PC", maddr, exp_pc);
    // decode
    tick();
    b_sel = 2'b11;
    check("R2 opcode after fetch", {26'd0, opc}, {26'd0, op});
    check("R2 PC+4 after fetch", pc, pc4);
    exp_pc = pc4;
    tick();
    case (op)
      OP_LW, OP_SW: begin
        a_sel = 1; b_sel = 2'b10;
        tick();
        addr_sel = 1;
        if (op == OP_LW) mem_re = 1; else mem_we = 1;
        #1 check("R4 data address from ALU register", maddr, ea);
        if (op == OP_LW) begin
          tick();
          reg_we = 1; wb_src = 1;
          if (rt != 0) exp_rf[rt] = mem[ea[11:2]];
          tick();
        end else begin
          tick();
          check({tag, " store data"}, mem[ea[11:2]], exp_rf[rt]);
        end
      end
      OP_R: begin
        a_sel = 1; aop = 2'b10;
        tick();
        reg_we = 1; wb_dst = 1;
        if (rd != 0) exp_rf[rd] = alu_ref(ins[5:0], exp_rf[rs], exp_rf[rt]);
        tick();
      end
      OP_BEQ: begin
        a_sel = 1; aop = 2'b01; pc_we_cond = 1; pc_src = 2'b01;
        if (exp_rf[rs] == exp_rf[rt]) exp_pc = pc4 + {sx(ins[15:0])[29:0], 2'b00};
        tick();
      end
      default: begin
        pc_we = 1; pc_src = 2'b10;
        exp_pc = {pc4[31:28], ins[25:0], 2'b00};
        tick();
      end
    endcase
    check({tag, " PC after instruction"}, pc, exp_pc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] fl [5];
    fl[0] = 6'h20; fl[1] = 6'h22; fl[2] = 6'h24; fl[3] = 6'h25; fl[4] = 6'h2a;
    void'($urandom(32'd1234));
    clr();
    for (int i = 0; i < MW; i++) mem[i] = 32'd0;
    for (int i = 0; i < 32; i++) exp_rf[i] = 32'd0;
    for (int k = 0; k < 16; k++) mem[768 + k] = $urandom;
    mem[768] = 32'hffff_fff0;  // negative operand for signed compare
    mem[769] = 32'h0000_0005;
    exp_pc = 32'd0;
    repeat (3) @(negedge clk);
    check("R1 PC after reset", pc, 32'd0);
    check("R1 no write after reset", {31'd0, mwe_o}, 32'd0);
    rst_n = 1'b1;

    // loads then signed compare (R5, R7)
    exec(enc_i(OP_LW, 0, 1, 16'h0c00), "R7 load r1");
    exec(enc_i(OP_LW, 0, 2, 16'h0c04), "R7 load r2");
    exec(enc_r(1, 2, 3, 6'h2a), "R5 slt neg<pos");
    exec(enc_i(OP_SW, 0, 3, 16'h0e00), "R5 R8 R11 slt result");
    exec(enc_r(2, 1, 4, 6'h2a), "R5 slt pos<neg");
    exec(enc_i(OP_SW, 0, 4, 16'h0e04), "R5 R11 slt zero result");
    // register zero (R6)
    exec(enc_i(OP_LW, 0, 0, 16'h0c04), "R6 load into r0");
    exec(enc_r(1, 2, 0, 6'h25), "R6 rtype into r0");
    exec(enc_i(OP_SW, 0, 0, 16'h0e08), "R6 r0 reads zero");
    // branch not taken, taken forward, taken backward (R3, R9)
    exec(enc_i(OP_BEQ, 1, 2, 16'h0010), "R9 beq not taken");
    exec(enc_i(OP_LW, 0, 5, 16'h0c00), "R7 load r5");
    exec(enc_i(OP_BEQ, 1, 5, 16'h0010), "R3 R9 beq taken forward");
    exec(enc_i(OP_BEQ, 0, 0, 16'hfff8), "R3 R9 beq taken backward");
    // store right after load to same address
    exec(enc_i(OP_LW, 0, 6, 16'h0c08), "R7 load r6");
    exec(enc_i(OP_SW, 0, 6, 16'h0c08), "R8 store after load");
    // random R-type mix
    for (int i = 0; i < 24; i++) begin
      int ra, rb, rd;
      ra = 1 + int'($urandom_range(0, 30));
      rb = 1 + int'($urandom_range(0, 30));
      rd = 1 + int'($urandom_range(0, 30));
      exec(enc_i(OP_LW, 0, ra, 16'(32'h0c00 + 4 * $urandom_range(0, 15))), "R7 random load");
      exec(enc_i(OP_LW, 0, rb, 16'(32'h0c00 + 4 * $urandom_range(0, 15))), "R7 random load");
      exec(enc_r(ra, rb, rd, fl[$urandom_range(0, 4)]), "R5 random rtype");
      exec(enc_i(OP_SW, 0, rd, 16'(32'h0e40 + 4 * i)), "R5 R8 R11 random result");
    end
    // jump (R10)
    exec({OP_J, 26'h0000240}, "R10 jump");
    exec(enc_i(OP_SW, 0, 1, 16'h0f00), "R8 store after jump");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule